// File: doc/BRIEF.md
# Gray-Coded Counter Pulse-Width Modulator

This block produces the gate drive bit for the power switch of a DC-DC chopper (buck, boost or buck-boost stage). The period counter runs freely and steps through Gray codes, so only one counter bit toggles on each clock. A binary duty word sets how many clock cycles of each period the output stays high. The PWM frequency is the input clock divided by 2^CNT_W. The duty word is converted to Gray code and registered once per period. A comparator works on every clock in the Gray domain and finds the cycle where the on-time ends.

A one-hot state machine with four states sequences the output. The states are idle, period start, on-phase and off-phase. The start and on states act as the set side of a set-reset latch, and a compare match acts as the reset side. Pulling the enable low parks the block: the output goes low, the counter returns to zero and the machine goes idle. The first enabled clock after that begins a fresh period.

Top module: `gray_pwm`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) drives the output low and the state machine idle from the next cycle, and clears the counter to code zero.
- R2: While enabled, the counter moves one Gray code per clock, so exactly one bit changes. It wraps from the last code (binary 2^CNT_W-1) to all zeros, so the period is 2^CNT_W clocks and the output's rising edges are 2^CNT_W clocks apart.
- R3: The binary duty word is captured and converted to Gray code at the edge where the counter holds its last code, and also on every edge with reset high or enable low. A change to the duty word at any other time has no effect until the next period.
- R4: The output goes high in the cycle after the edge where the counter is at zero. It returns low in the cycle after the edge where the counter equals the captured duty. It is therefore high for exactly D cycles per period, where D is the captured duty.
- R5: A captured duty of 0 keeps the output low for the whole period.
- R6: A captured duty of 2^CNT_W-1 keeps the output high for all but one cycle of the period.
- R7: An edge with enable low drives the output low from the next cycle, returns the counter to zero and puts the state machine in idle. The first enabled edge after that starts a period, with the output high in the next cycle when the duty is nonzero.
- R8: The state register always holds exactly one set bit. Any other pattern recovers to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; sets the PWM time base |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks the block with the output low |
| duty | input | CNT_W | Binary on-time in clock cycles per period |
| pwm_o | output | 1 | PWM drive bit |

## Verification
Assertions check these rules on every cycle: the single-bit Gray step and the wrap to zero, the zeroed counter while disabled, a captured duty that stays fixed for the whole period, the one-hot state, the output low after a match, the output high after a period start, and idle after reset or disable. Only the bench scenarios can show the numbers that span a period. These are the exact high time against the duty over whole periods, the rising-edge spacing of 2^CNT_W clocks, and the deferred effect of a duty change made mid-period. The bench runs directed cases (duty 0, full duty, changes just before the wrap, enable drops) and then random duty and enable sequences.

// File: rtl/gray_pwm_pkg.sv
package gray_pwm_pkg;
   localparam int ST_W      = 4;
   localparam int IDX_IDLE  = 0;
   localparam int IDX_START = 1;
   localparam int IDX_ON    = 2;
   localparam int IDX_OFF   = 3;

   typedef logic [ST_W-1:0] pwm_state_t;

   localparam pwm_state_t ST_IDLE  = pwm_state_t'(1) << IDX_IDLE;
   localparam pwm_state_t ST_START = pwm_state_t'(1) << IDX_START;
   localparam pwm_state_t ST_ON    = pwm_state_t'(1) << IDX_ON;
   localparam pwm_state_t ST_OFF   = pwm_state_t'(1) << IDX_OFF;
endpackage

// File: rtl/gpwm_gray_counter.sv
module gpwm_gray_counter #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   output logic [W-1:0] cnt_g,
   output logic         at_zero,
   output logic         at_last
);
   localparam logic [W-1:0] LAST_G = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] cnt_q;
   logic [W-1:0] bin_now;
   logic [W-1:0] bin_inc;
   logic [W-1:0] cnt_d;

   // Gray to binary: each binary bit is the parity of the Gray bits at and above it
   for (genvar i = 0; i < W; i++) begin : g_g2b
      assign bin_now[i] = ^cnt_q[W-1:i];
   end

   assign bin_inc = bin_now + 1'b1;
   assign cnt_d   = bin_inc ^ (bin_inc >> 1);

   always_ff @(posedge clk) begin
      if (rst || !en) cnt_q <= '0;
      else            cnt_q <= cnt_d;
   end

   assign cnt_g   = cnt_q;
   assign at_zero = (cnt_q == '0);
   assign at_last = (cnt_q == LAST_G);

   AST_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
      en |=> ($countones(cnt_q ^ $past(cnt_q)) == 1)); // R2
   AST_GRAY_WRAP: assert property (@(posedge clk) disable iff (rst)
      (en && cnt_q == LAST_G) |=> (cnt_q == '0)); // R2
   AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
      !en |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/gpwm_duty_cmp.sv
module gpwm_duty_cmp #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] duty,
   input  logic [W-1:0] cnt_g,
   input  logic         at_last,
   output logic         match
);
   logic [W-1:0] duty_gray;
   logic [W-1:0] duty_g_q;
   logic         load;

   assign duty_gray = duty ^ (duty >> 1);
   assign load      = rst || !en || at_last;

   always_ff @(posedge clk) begin
      if (load) duty_g_q <= duty_gray;
   end

   assign match = (cnt_g == duty_g_q);

   AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (en && !at_last) |=> $stable(duty_g_q)); // R3
endmodule

// File: rtl/gpwm_onehot_fsm.sv
module gpwm_onehot_fsm
   import gray_pwm_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic at_zero,
   input  logic match,
   output logic pwm_o
);
   pwm_state_t state_q;
   pwm_state_t state_d;
   logic       sr_set;
   logic       sr_clr;

   // latch set at period start, cleared on compare match (clear wins)
   assign sr_clr = match;
   assign sr_set = at_zero && !match;

   always_comb begin
      if (!en || !$onehot(state_q))            state_d = ST_IDLE;
      else if (sr_clr)                         state_d = ST_OFF;
      else if (sr_set)                         state_d = ST_START;
      else if (state_q[IDX_START] || state_q[IDX_ON]) state_d = ST_ON;
      else                                     state_d = ST_OFF;
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign pwm_o = state_q[IDX_START] || state_q[IDX_ON];

   AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
      $onehot(state_q)); // R8
   AST_RST_IDLE: assert property (@(posedge clk)
      rst |=> (state_q == ST_IDLE && !pwm_o)); // R1
   AST_OFF_AFTER_MATCH: assert property (@(posedge clk) disable iff (rst)
      (en && match) |=> !pwm_o); // R4
   AST_HIGH_AT_START: assert property (@(posedge clk) disable iff (rst)
      (en && at_zero && !match) |=> pwm_o); // R4
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
      !en |=> (state_q == ST_IDLE && !pwm_o)); // R7
endmodule

// File: rtl/gray_pwm.sv
module gray_pwm #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [CNT_W-1:0] duty,
   output logic             pwm_o
);
   localparam int MIN_W = 2;
   localparam int MAX_W = 16;

   if (CNT_W < MIN_W || CNT_W > MAX_W) begin : g_bad_width
      $error("gray_pwm: CNT_W out of supported range");
   end

   logic [CNT_W-1:0] cnt_g;
   logic             at_zero;
   logic             at_last;
   logic             match;

   gpwm_gray_counter #(.W(CNT_W)) u_counter (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .cnt_g   (cnt_g),
      .at_zero (at_zero),
      .at_last (at_last)
   );

   gpwm_duty_cmp #(.W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .duty    (duty),
      .cnt_g   (cnt_g),
      .at_last (at_last),
      .match   (match)
   );

   gpwm_onehot_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .at_zero (at_zero),
      .match   (match),
      .pwm_o   (pwm_o)
   );
endmodule

// File: tb/gray_pwm_bench.sv
module gray_pwm_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W      = 6;
   localparam int PERIOD = 1 << W;
   localparam int MAXD   = PERIOD - 1;

   logic         clk  = 1'b0;
   logic         rst  = 1'b1;
   logic         en   = 1'b0;
   logic [W-1:0] duty = '0;
   logic         pwm;

   always #(CLK_PERIOD/2) clk = ~clk;

   gray_pwm #(.CNT_W(W)) u_gray_pwm (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .duty  (duty),
      .pwm_o (pwm)
   );

   int checks   = 0;
   int failures = 0;

   task automatic check(input bit ok, input string req, input int act,
                        input int exp, input string what);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit exp_high(input int idx, input int d);
      return idx < d;
   endfunction

   function automatic int next_idx(input int idx);
      return (idx + 1) % PERIOD;
   endfunction

   // requirement model: position in period, captured duty, expected output
   int m_idx  = 0;
   int m_dlat = 0;
   bit m_pwm  = 1'b0;
   bit m_run  = 1'b0;

   always @(posedge clk) begin
      m_pwm  <= !rst && en && exp_high(m_idx, m_dlat);
      m_run  <= !rst && en;
      m_idx  <= (rst || !en) ? 0 : next_idx(m_idx);
      m_dlat <= (rst || !en || m_idx == MAXD) ? int'(duty) : m_dlat;
   end

   bit mon_on   = 1'b0;
   int hi       = 0;
   int pd       = 0;
   int gap      = 0;
   bit win      = 1'b0;
   bit gap_ok   = 1'b0;
   bit prev_pwm = 1'b0;

   always @(negedge clk) begin
      if (mon_on) begin
         check(pwm === m_pwm, "R3/R4", int'(pwm), int'(m_pwm), "cycle output");
         if (!m_run) begin
            win = 1'b0; hi = 0; gap = 0; gap_ok = 1'b0;
         end else begin
            if (m_idx == 1) begin
               hi = int'(pwm); pd = m_dlat; win = 1'b1;
               if (!pwm) gap_ok = 1'b0;
            end else begin
               hi += int'(pwm);
            end
            if (m_idx == 0 && win)
               check(hi == pd, (pd == 0) ? "R5" : ((pd == MAXD) ? "R6" : "R4"),
                     hi, pd, "high time per period");
            gap++;
            if (pwm && !prev_pwm) begin
               if (gap_ok) check(gap == PERIOD, "R2", gap, PERIOD, "rising edge spacing");
               gap_ok = 1'b1;
               gap    = 0;
            end
         end
      end
      prev_pwm = pwm;
   end

   task automatic run_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_idx(input int k);
      while (m_idx != k) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      void'($urandom(32'd2024));
      run_cycles(3);
      check(pwm == 1'b0, "R1", int'(pwm), 0, "output under reset");
      mon_on = 1'b1;

      rst = 1'b0; en = 1'b1; duty = W'(20);
      run_cycles(3 * PERIOD);
      duty = '0;          run_cycles(2 * PERIOD);    // R5
      duty = W'(MAXD);    run_cycles(2 * PERIOD);    // R6
      duty = W'(1);       run_cycles(2 * PERIOD);

      // mid-period change deferred to next period (R3)
      duty = W'(10);
      run_cycles(PERIOD);
      wait_idx(5);
      duty = W'(50);
      wait_idx(30);
      check(pwm == 1'b0, "R3", int'(pwm), 0, "mid-period duty change ignored");
      run_cycles(2 * PERIOD);
      wait_idx(MAXD);
      duty = W'(7);       run_cycles(2 * PERIOD);

      // enable drop while high, then restart (R7, R8)
      duty = W'(10);
      run_cycles(PERIOD);
      wait_idx(5);
      en = 1'b0;
      @(negedge clk);
      check(pwm == 1'b0, "R7", int'(pwm), 0, "output low after disable");
      run_cycles(3);
      en = 1'b1;
      @(negedge clk);
      check(pwm == 1'b1, "R8", int'(pwm), 1, "idle state restarts period");
      run_cycles(2 * PERIOD);

      // reset mid-run (R1)
      wait_idx(4);
      rst = 1'b1;
      @(negedge clk);
      check(pwm == 1'b0, "R1", int'(pwm), 0, "output low after reset");
      rst = 1'b0;
      run_cycles(2 * PERIOD);

      // random duty and enable sequences
      for (int n = 0; n < 40; n++) begin
         int sel;
         sel = int'($urandom % 8);
         if (sel == 0)      duty = '0;
         else if (sel == 1) duty = W'(MAXD);
         else               duty = W'($urandom % PERIOD);
         if ($urandom % 10 == 0) begin
            en = 1'b0;
            run_cycles(int'($urandom_range(1, 4)));
            en = 1'b1;
         end
         run_cycles(int'($urandom_range(5, 200)));
      end
      run_cycles(2 * PERIOD);
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end
endmodule